// File: doc/BRIEF.md
# Branch and Skip Condition Evaluator

This block decides, for one instruction at a time, whether control flow changes and how a register is rewritten by a bit-test. It handles three instruction classes. A conditional jump compares a register against zero. A compare-skip compares a register against a memory operand. A bit-test takes half of the operand as a mask over one half of the register. It decides a skip on the selected bits and, in the same operation, can clear, invert or set those bits.

The block is purely combinational. The issuing pipeline stage presents the class, condition code, register value, operand, half select and modify mode. In the same cycle it reads back a jump decision, a skip decision and the register value to write back. Program-counter arithmetic and memory traffic stay in the surrounding stage. All pins are plain control and data pins with no handshake, because every result is available in the cycle its inputs are presented.

Top module: `tcu_branch_unit`

## Requirements
- R1: In the jump class (cls_i = 0), the register is compared as a signed WORD_W-bit number against zero. cond_i selects the test: 0 never, 1 less, 2 equal, 3 less-or-equal, 4 always, 5 greater-or-equal, 6 not-equal, 7 greater. jump_taken_o follows that test.
- R2: cond_i = 0 never asserts jump_taken_o or skip_next_o. cond_i = 4 asserts the decision output of the jump, compare and test classes unconditionally.
- R3: A jump with cond_i = 6 is taken exactly when the register is non-zero.
- R4: In the compare class (cls_i = 1), the register is compared as a signed number against the full operand. skip_next_o follows cond_i with the same codes as R1. For example, code 6 skips when the two differ.
- R5: jump_taken_o is asserted only in the jump class. skip_next_o is asserted only in the compare and test classes. With cls_i = 3 (idle), neither is asserted, so at most one of them is ever high.
- R6: In the test class (cls_i = 2) with half_sel_i = 0, the lower half of the operand masks the upper half of the register. The selected bits count as "equal" when all are zero. In this class "less" is never true, so code 1 never skips, 3 acts as 2, 5 always skips and 7 acts as 6.
- R7: In the test class with half_sel_i = 1, the same mask is applied to the lower half of the register instead.
- R8: In the test class, mod_mode_i rewrites the selected bits: 0 keeps them, 1 clears them, 2 inverts them and 3 sets them to ones. Bits outside the mask are unchanged, and the rewrite happens whether or not the skip is taken.
- R9: The test-class skip decision uses the selected bits as they were before the rewrite.
- R10: Outside the test class, reg_out_o equals reg_val_i regardless of mod_mode_i and half_sel_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cls_i | input | 2 | Instruction class: 0 jump, 1 compare, 2 test, 3 idle |
| cond_i | input | 3 | Condition code |
| half_sel_i | input | 1 | Test half: 0 upper, 1 lower |
| mod_mode_i | input | 2 | Test rewrite: 0 keep, 1 clear, 2 invert, 3 set |
| reg_val_i | input | WORD_W | Register contents |
| operand_i | input | WORD_W | Memory operand or effective address |
| jump_taken_o | output | 1 | Jump decision |
| skip_next_o | output | 1 | Skip decision |
| reg_out_o | output | WORD_W | Register value to write back |

## Verification
All three results depend only on the present inputs, so each is due in the same cycle as its stimulus, with no register on the path. The bench changes the inputs on the falling clock edge. It samples all outputs a fixed delay later, well before the next rising edge, so each check sees the settled response to exactly one stimulus. The checks compare against values derived by hand from the requirements. These include signed extremes, empty and full masks, and the test cases where the skip must reflect the bits before they are rewritten.

// File: rtl/tcu_pkg.sv
package tcu_pkg;
  typedef enum logic [1:0] {
    CLS_JUMP = 2'd0,
    CLS_CMP  = 2'd1,
    CLS_TEST = 2'd2,
    CLS_IDLE = 2'd3
  } cls_e;

  typedef enum logic [1:0] {
    MOD_KEEP = 2'd0,
    MOD_ZERO = 2'd1,
    MOD_FLIP = 2'd2,
    MOD_ONES = 2'd3
  } mod_e;

  localparam int COND_W = 3;
endpackage

// File: rtl/tcu_signed_cmp.sv
module tcu_signed_cmp #(
  parameter int WORD_W = 36
) (
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic              less_o,
  output logic              equal_o
);
  always_comb begin
    less_o  = $signed(a_i) < $signed(b_i);
    equal_o = (a_i == b_i);
  end
endmodule

// File: rtl/tcu_cond_eval.sv
module tcu_cond_eval
  import tcu_pkg::*;
(
  input  logic              less_i,
  input  logic              equal_i,
  input  logic [COND_W-1:0] cond_i,
  output logic              hit_o
);
  logic base;
  // low two bits pick false/less/equal/less-or-equal; top bit negates
  always_comb begin
    unique case (cond_i[1:0])
      2'd0:    base = 1'b0;
      2'd1:    base = less_i;
      2'd2:    base = equal_i;
      default: base = less_i | equal_i;
    endcase
    hit_o = base ^ cond_i[COND_W-1];
  end
endmodule

// File: rtl/tcu_field_mod.sv
module tcu_field_mod
  import tcu_pkg::*;
#(
  parameter int WORD_W = 36
) (
  input  logic [WORD_W-1:0] reg_i,
  input  logic [WORD_W-1:0] operand_i,
  input  logic              half_sel_i,
  input  logic [1:0]        mode_i,
  output logic              sel_zero_o,
  output logic [WORD_W-1:0] reg_o
);
  localparam int HALF_W = WORD_W / 2;

  logic [HALF_W-1:0] mask;
  logic [WORD_W-1:0] full_mask;

  assign mask = operand_i[HALF_W-1:0];

  generate
    if (2 * HALF_W == WORD_W) begin : g_even
      assign full_mask = half_sel_i ? {{HALF_W{1'b0}}, mask}
                                    : {mask, {HALF_W{1'b0}}};
    end else begin : g_odd
      assign full_mask = half_sel_i ? {{(WORD_W-HALF_W){1'b0}}, mask}
                                    : {mask, {(WORD_W-HALF_W){1'b0}}};
    end
  endgenerate

  always_comb begin
    sel_zero_o = ((reg_i & full_mask) == '0);
    unique case (mod_e'(mode_i))
      MOD_ZERO: reg_o = reg_i & ~full_mask;
      MOD_FLIP: reg_o = reg_i ^ full_mask;
      MOD_ONES: reg_o = reg_i | full_mask;
      default:  reg_o = reg_i;
    endcase
  end
endmodule

// File: rtl/tcu_branch_unit.sv
module tcu_branch_unit
  import tcu_pkg::*;
#(
  parameter int WORD_W = 36
) (
  input  logic [1:0]        cls_i,
  input  logic [2:0]        cond_i,
  input  logic              half_sel_i,
  input  logic [1:0]        mod_mode_i,
  input  logic [WORD_W-1:0] reg_val_i,
  input  logic [WORD_W-1:0] operand_i,
  output logic              jump_taken_o,
  output logic              skip_next_o,
  output logic [WORD_W-1:0] reg_out_o
);
  cls_e              cls;
  logic [WORD_W-1:0] cmp_rhs;
  logic              cmp_less, cmp_equal;
  logic              sel_zero;
  logic [WORD_W-1:0] test_reg;
  logic              use_less, use_equal;
  logic              hit;

  assign cls = cls_e'(cls_i);

  // one comparator serves both jump (against zero) and compare classes
  assign cmp_rhs = (cls == CLS_JUMP) ? '0 : operand_i;

  tcu_signed_cmp #(.WORD_W(WORD_W)) u_cmp (
    .a_i     (reg_val_i),
    .b_i     (cmp_rhs),
    .less_o  (cmp_less),
    .equal_o (cmp_equal)
  );

  tcu_field_mod #(.WORD_W(WORD_W)) u_mod (
    .reg_i      (reg_val_i),
    .operand_i  (operand_i),
    .half_sel_i (half_sel_i),
    .mode_i     (mod_mode_i),
    .sel_zero_o (sel_zero),
    .reg_o      (test_reg)
  );

  // test class has no ordering: "less" is never true there
  always_comb begin
    if (cls == CLS_TEST) begin
      use_less  = 1'b0;
      use_equal = sel_zero;
    end else begin
      use_less  = cmp_less;
      use_equal = cmp_equal;
    end
  end

  tcu_cond_eval u_cond (
    .less_i  (use_less),
    .equal_i (use_equal),
    .cond_i  (cond_i),
    .hit_o   (hit)
  );

  always_comb begin
    jump_taken_o = (cls == CLS_JUMP) & hit;
    skip_next_o  = ((cls == CLS_CMP) | (cls == CLS_TEST)) & hit;
    reg_out_o    = (cls == CLS_TEST) ? test_reg : reg_val_i;
  end
endmodule

// File: rtl/tcu_branch_unit_chk.sv
module tcu_branch_unit_chk #(
  parameter int WORD_W = 36
) (
  input logic [1:0]        cls_i,
  input logic [2:0]        cond_i,
  input logic              half_sel_i,
  input logic [1:0]        mod_mode_i,
  input logic [WORD_W-1:0] reg_val_i,
  input logic [WORD_W-1:0] operand_i,
  input logic              jump_taken_o,
  input logic              skip_next_o,
  input logic [WORD_W-1:0] reg_out_o
);
  localparam int HALF_W = WORD_W / 2;
  logic [WORD_W-1:0] sel_bits;
  logic              known;

  always_comb begin
    sel_bits = '0;
    if (half_sel_i) sel_bits[HALF_W-1:0] = operand_i[HALF_W-1:0];
    else            sel_bits[WORD_W-1:WORD_W-HALF_W] = operand_i[HALF_W-1:0];
    known = !$isunknown({cls_i, cond_i, half_sel_i, mod_mode_i, reg_val_i,
                         operand_i, jump_taken_o, skip_next_o, reg_out_o});
  end

  always_comb begin
    if (known) begin
      AST_ONE_DECISION: assert (!(jump_taken_o && skip_next_o)); // R5
      AST_JUMP_CLASS_ONLY: assert (!jump_taken_o || cls_i == 2'd0); // R5
      AST_IDLE_QUIET: assert (cls_i != 2'd3 || (!jump_taken_o && !skip_next_o)); // R5
      AST_NEVER_CODE: assert (cond_i != 3'd0 || (!jump_taken_o && !skip_next_o)); // R2
      AST_ALWAYS_CODE: assert (cond_i != 3'd4 || cls_i == 2'd3 || jump_taken_o || skip_next_o); // R2
      AST_JUMP_NONZERO: assert (cls_i != 2'd0 || cond_i != 3'd6 || jump_taken_o == (reg_val_i != '0)); // R3
      AST_PASS_THROUGH: assert (cls_i == 2'd2 || reg_out_o == reg_val_i); // R10
      AST_OUTSIDE_MASK: assert (cls_i != 2'd2 || ((reg_out_o ^ reg_val_i) & ~sel_bits) == '0); // R8
      AST_FLIP_ALL: assert (cls_i != 2'd2 || mod_mode_i != 2'd2 || (reg_out_o ^ reg_val_i) == sel_bits); // R8
    end
  end
endmodule

bind tcu_branch_unit tcu_branch_unit_chk #(.WORD_W(WORD_W)) u_chk (
  .cls_i        (cls_i),
  .cond_i       (cond_i),
  .half_sel_i   (half_sel_i),
  .mod_mode_i   (mod_mode_i),
  .reg_val_i    (reg_val_i),
  .operand_i    (operand_i),
  .jump_taken_o (jump_taken_o),
  .skip_next_o  (skip_next_o),
  .reg_out_o    (reg_out_o)
);

// File: tb/tcu_branch_unit_bench.sv
module tcu_branch_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 36;

  typedef struct packed {
    logic [1:0]   cls;
    logic [2:0]   cond;
    logic         half;
    logic [1:0]   mode;
    logic [W-1:0] rv;
    logic [W-1:0] op;
    logic         ej;
    logic         es;
    logic [W-1:0] eo;
    logic [3:0]   req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 3'd0, 1'b0, 2'd0, 36'd5, 36'd0, 1'b0, 1'b0, 36'd5, 4'd2},                 // R2 never
    '{2'd0, 3'd4, 1'b0, 2'd0, 36'd0, 36'd0, 1'b1, 1'b0, 36'd0, 4'd2},                 // R2 always
    '{2'd0, 3'd6, 1'b0, 2'd0, 36'd0, 36'd0, 1'b0, 1'b0, 36'd0, 4'd3},                 // R3 zero
    '{2'd0, 3'd6, 1'b0, 2'd0, 36'd1, 36'd0, 1'b1, 1'b0, 36'd1, 4'd3},                 // R3 nonzero
    '{2'd0, 3'd1, 1'b0, 2'd0, 36'h800000000, 36'd0, 1'b1, 1'b0, 36'h800000000, 4'd1}, // R1 less
    '{2'd0, 3'd7, 1'b0, 2'd0, 36'h800000000, 36'd0, 1'b0, 1'b0, 36'h800000000, 4'd1}, // R1 greater
    '{2'd0, 3'd3, 1'b0, 2'd0, 36'd0, 36'd9, 1'b1, 1'b0, 36'd0, 4'd1},                 // R1 le at zero
    '{2'd0, 3'd5, 1'b0, 2'd0, 36'd3, 36'd0, 1'b1, 1'b0, 36'd3, 4'd1},                 // R1 ge
    '{2'd0, 3'd2, 1'b0, 2'd0, 36'd3, 36'd0, 1'b0, 1'b0, 36'd3, 4'd1},                 // R1 equal miss
    '{2'd1, 3'd6, 1'b0, 2'd0, 36'd7, 36'd7, 1'b0, 1'b0, 36'd7, 4'd4},                 // R4 same
    '{2'd1, 3'd6, 1'b0, 2'd0, 36'd7, 36'd8, 1'b0, 1'b1, 36'd7, 4'd4},                 // R4 differ
    '{2'd1, 3'd1, 1'b0, 2'd0, 36'hFFFFFFFFF, 36'd1, 1'b0, 1'b1, 36'hFFFFFFFFF, 4'd4}, // R4 signed less
    '{2'd1, 3'd5, 1'b0, 2'd0, 36'hFFFFFFFFF, 36'd1, 1'b0, 1'b0, 36'hFFFFFFFFF, 4'd4}, // R4 signed ge
    '{2'd1, 3'd0, 1'b0, 2'd0, 36'd1, 36'd2, 1'b0, 1'b0, 36'd1, 4'd2},                 // R2 never cmp
    '{2'd2, 3'd2, 1'b0, 2'd0, {18'h00003, 18'h0}, 36'h4, 1'b0, 1'b1, {18'h00003, 18'h0}, 4'd6}, // R6 zero sel
    '{2'd2, 3'd2, 1'b0, 2'd2, {18'h00003, 18'h0}, 36'h3, 1'b0, 1'b0, 36'd0, 4'd9},    // R9 flip, no skip
    '{2'd2, 3'd2, 1'b0, 2'd2, {18'h00003, 18'h0}, 36'h4, 1'b0, 1'b1, {18'h00007, 18'h0}, 4'd8}, // R8 flip
    '{2'd2, 3'd6, 1'b1, 2'd1, {18'h3FFFF, 18'h000F0}, 36'h0FF, 1'b0, 1'b1, {18'h3FFFF, 18'h0}, 4'd7}, // R7 clear
    '{2'd2, 3'd2, 1'b1, 2'd3, 36'd0, 36'h00F, 1'b0, 1'b1, 36'h00F, 4'd7},             // R7 set
    '{2'd2, 3'd1, 1'b0, 2'd2, 36'd0, 36'd1, 1'b0, 1'b0, {18'h00001, 18'h0}, 4'd6},    // R6 lt never
    '{2'd2, 3'd5, 1'b0, 2'd0, {18'h00001, 18'h0}, 36'd1, 1'b0, 1'b1, {18'h00001, 18'h0}, 4'd6}, // R6 ge always
    '{2'd3, 3'd4, 1'b0, 2'd3, 36'd11, 36'd11, 1'b0, 1'b0, 36'd11, 4'd5},              // R5 idle
    '{2'd0, 3'd6, 1'b1, 2'd3, 36'd12, 36'hFFF, 1'b1, 1'b0, 36'd12, 4'd10}             // R10 mode ignored
  };

  logic clk = 1'b0;
  logic [1:0]   cls_i = 2'd3;
  logic [2:0]   cond_i = 3'd0;
  logic         half_sel_i = 1'b0;
  logic [1:0]   mod_mode_i = 2'd0;
  logic [W-1:0] reg_val_i = '0;
  logic [W-1:0] operand_i = '0;
  logic         jump_taken_o, skip_next_o;
  logic [W-1:0] reg_out_o;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tcu_branch_unit #(.WORD_W(W)) u_tcu_branch_unit (
    .cls_i(cls_i), .cond_i(cond_i), .half_sel_i(half_sel_i),
    .mod_mode_i(mod_mode_i), .reg_val_i(reg_val_i), .operand_i(operand_i),
    .jump_taken_o(jump_taken_o), .skip_next_o(skip_next_o), .reg_out_o(reg_out_o)
  );

  task automatic apply(input logic [1:0] c, input logic [2:0] cd, input logic h,
                       input logic [1:0] m, input logic [W-1:0] r, input logic [W-1:0] o);
    @(negedge clk);
    cls_i = c; cond_i = cd; half_sel_i = h; mod_mode_i = m;
    reg_val_i = r; operand_i = o;
    #2;
  endtask

  task automatic check(input int req, input logic ej, input logic es, input logic [W-1:0] eo);
    n_checks++;
    if (jump_taken_o !== ej || skip_next_o !== es || reg_out_o !== eo) begin
      n_fail++;
      $display("FAIL R%0d: got j=%b s=%b out=%h, expected j=%b s=%b out=%h",
               req, jump_taken_o, skip_next_o, reg_out_o, ej, es, eo);
    end
  endtask

  initial begin
    // idle state after start (R5): no decision, value passes through
    #3;
    check(5, 1'b0, 1'b0, '0);
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].cls, VEC[i].cond, VEC[i].half, VEC[i].mode, VEC[i].rv, VEC[i].op);
      check(int'(VEC[i].req), VEC[i].ej, VEC[i].es, VEC[i].eo);
    end
    // R4 extremes: most negative vs most positive
    apply(2'd1, 3'd1, 1'b0, 2'd0, 36'h800000000, 36'h7FFFFFFFF);
    check(4, 1'b0, 1'b1, 36'h800000000);
    apply(2'd1, 3'd7, 1'b0, 2'd0, 36'h7FFFFFFFF, 36'h800000000);
    check(4, 1'b0, 1'b1, 36'h7FFFFFFFF);
    // R8 full upper mask inverted, R9 skip from original bits
    apply(2'd2, 3'd6, 1'b0, 2'd2, 36'h123456789, 36'h3FFFF);
    check(8, 1'b0, 1'b1, 36'h123456789 ^ {18'h3FFFF, 18'h0});
    // R6 empty mask: equal always skips, nothing rewritten
    apply(2'd2, 3'd2, 1'b0, 2'd3, 36'hFFFFFFFFF, 36'hFFFC0000);
    check(6, 1'b0, 1'b1, 36'hFFFFFFFFF);
    // R2 always in test class
    apply(2'd2, 3'd4, 1'b1, 2'd0, 36'd1, 36'd1);
    check(2, 1'b0, 1'b1, 36'd1);
    // R10 compare class ignores the rewrite mode
    apply(2'd1, 3'd2, 1'b0, 2'd1, 36'hABC, 36'hABC);
    check(10, 1'b0, 1'b1, 36'hABC);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule